// File: doc/BRIEF.md
# Three-Channel Input Gamma Lookup Table

This block corrects each colour component of a pixel stream through its own lookup table before further processing. Four banks of tables are kept. Each bank holds one 256-entry, 12-bit table per component. Software reaches the tables through three 32-bit port registers, one per component, at word offsets 0, 1 and 2 (byte offsets 0, 4 and 8). A fourth register at word offset 3 holds the operating mode.

Each port keeps its own entry counter, and the load path and the readback path share that counter. A write names its target bank with a four-bit mask in which only the chosen bank's bit is cleared. The write stores its low twelve data bits into the current entry, and the counter then steps forward by itself. A control bit returns the counter to entry 0 before the store. A second control bit, set together with the first, turns the write into a readback arm. Reads then stream out successive entries from the bank that the arm named.

A full table load touches each index in turn. For every index it writes channel 0, then channel 1, then channel 2. The pixel path takes three 8-bit components and returns three 12-bit values one cycle later. It either looks each component up in the bank selected by the mode register, or passes the component through, zero-extended.

Top module: `gamma_lut`

## Requirements
- R1: After reset, pixOutValid is 0, pixOut is 0, the mode register reads 0, and every port counter is at entry 0.
- R2: regAddr 0, 1 and 2 select the port of channel 0, 1 and 2. regAddr 3 is the mode register: bit 0 enables lookup, bits 2:1 select the bank used by the pixel path, and a read returns these three bits with every higher bit 0.
- R3: A port write with bits 24 and 25 clear and a valid mask stores regWdata[11:0] at the port's current entry in the addressed bank. The counter then advances by one and wraps from 255 to 0. Port reads share and advance the same counter.
- R4: A write with bit 25 set and bit 24 clear stores its data at entry 0 and leaves the counter at 1.
- R5: Bits 31:28 form the bank mask. It is valid only when exactly one bit is 0, and the position of that bit is the bank number. A write with an invalid mask stores nothing and does not advance the counter, but bit 25 still returns the counter to 0.
- R6: A write with bits 24 and 25 both set stores nothing. It returns the port's counter to 0 and, when the mask is valid, selects that mask's bank as the port's readback bank.
- R7: A read of a port returns the 12-bit entry of its readback bank at the current counter in regRdata[11:0], with bits 31:12 at 0. The counter advances after the read. regWr and regRd are never both high in the same cycle.
- R8: The three port counters are independent. Writes and reads on one port never move another port's counter.
- R9: A pixel presented with pixInValid appears one cycle later with pixOutValid high. When lookup is enabled, channel c (input bits 8c+7:8c, output bits 12c+11:12c) holds that component's table entry in the mode-selected bank. With no valid input, pixOutValid drops and pixOut holds.
- R10: With lookup disabled, each output channel equals its input component zero-extended to 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 2 | Word offset: 0 to 2 are channel ports, 3 is the mode register |
| regWdata | input | 32 | Write data, including the control bits and the bank mask |
| regRdata | output | 32 | Read data for the addressed register, combinational |
| pixInValid | input | 1 | Input pixel valid |
| pixIn | input | 24 | Three 8-bit components, channel 0 in the low byte |
| pixOutValid | output | 1 | Output pixel valid, one cycle after input |
| pixOut | output | 36 | Three 12-bit corrected components, channel 0 in the low bits |

## Verification
The checker relies on software never issuing a read and a write to the register port in the same cycle. The bench drives every access through tasks that raise exactly one strobe for one cycle, so this rule always holds. The bypass and latency properties assume that pixIn is meaningful only while pixInValid is high. The stimulus changes pixIn only together with that strobe, and it programs every table entry it later looks up, so no lookup reads an unwritten entry.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int CHANNELS = 3;
  localparam int NBANK    = 4;
  localparam int BANK_W   = 2;
  localparam int ENTRY_W  = 12;
  localparam int REG_W    = 32;
  localparam int MODE_W   = 3;
  localparam int RST_BIT  = 25;
  localparam int ARM_BIT  = 24;
  localparam int MASK_LSB = 28;
  localparam logic [1:0] MODE_ADDR = 2'd3;

  typedef logic [BANK_W-1:0] bank_t;

  // Strobes from control to datapath for one table store
  typedef struct packed {
    logic [CHANNELS-1:0] store;
    bank_t               storeBank;
    logic [ENTRY_W-1:0]  storeData;
  } lut_strobe_t;
endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWr,
  input  logic                              regRd,
  input  logic [1:0]                        regAddr,
  input  logic [REG_W-1:0]                  regWdata,
  output lut_strobe_t                       stb,
  output logic [IDX_W-1:0]                  storeIdx,
  output logic [CHANNELS-1:0][IDX_W-1:0]    chIdx,
  output logic [CHANNELS-1:0][BANK_W-1:0]   rdBank,
  output logic [MODE_W-1:0]                 modeBits
);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [NBANK-1:0] maskField;
  logic             maskOk;
  bank_t            maskBank;
  logic             rstFlag;
  logic             armFlag;
  logic [IDX_W-1:0] curIdx;
  logic             unusedWdata;

  assign maskField   = regWdata[MASK_LSB +: NBANK];
  assign rstFlag     = regWdata[RST_BIT];
  assign armFlag     = regWdata[ARM_BIT];
  assign unusedWdata = ^{regWdata[27:26], regWdata[23:12]};

  // Bank decode: exactly one cleared bit names the bank
  always_comb begin
    maskOk   = ($countones(~maskField) == 1);
    maskBank = '0;
    for (int b = 0; b < NBANK; b++)
      if (!maskField[b]) maskBank = BANK_W'(b);
  end

  always_comb begin
    curIdx = '0;
    for (int c = 0; c < CHANNELS; c++)
      if (regAddr == 2'(c)) curIdx = chIdx[c];
  end

  always_comb begin
    stb.storeBank = maskBank;
    stb.storeData = regWdata[ENTRY_W-1:0];
    for (int c = 0; c < CHANNELS; c++)
      stb.store[c] = regWr && (regAddr == 2'(c)) && maskOk && !armFlag;
    storeIdx = rstFlag ? '0 : curIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chIdx    <= '0;
      rdBank   <= '0;
      modeBits <= '0;
    end else begin
      if (regWr && regAddr == MODE_ADDR) modeBits <= regWdata[MODE_W-1:0];
      for (int c = 0; c < CHANNELS; c++) begin
        if (regWr && regAddr == 2'(c)) begin
          if (armFlag) begin
            if (rstFlag) chIdx[c] <= '0;
            if (maskOk)  rdBank[c] <= maskBank;
          end else if (maskOk) begin
            chIdx[c] <= (rstFlag ? '0 : chIdx[c]) + IDX_ONE;
          end else if (rstFlag) begin
            chIdx[c] <= '0;
          end
        end else if (regRd && regAddr == 2'(c)) begin
          chIdx[c] <= chIdx[c] + IDX_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/gamma_lut_datapath.sv
module gamma_lut_datapath
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  lut_strobe_t                       stb,
  input  logic [IDX_W-1:0]                  storeIdx,
  input  logic [CHANNELS-1:0][IDX_W-1:0]    chIdx,
  input  logic [CHANNELS-1:0][BANK_W-1:0]   rdBank,
  input  logic [MODE_W-1:0]                 modeBits,
  input  logic [1:0]                        regAddr,
  output logic [REG_W-1:0]                  regRdata,
  input  logic                              pixInValid,
  input  logic [CHANNELS*IDX_W-1:0]         pixIn,
  output logic                              pixOutValid,
  output logic [CHANNELS*ENTRY_W-1:0]       pixOut
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] table_q [NBANK][CHANNELS][DEPTH];
  logic [ENTRY_W-1:0] rdEntry;
  logic               lutOn;
  bank_t              pixBank;

  assign lutOn   = modeBits[0];
  assign pixBank = modeBits[2:1];

  always_ff @(posedge clk) begin
    for (int c = 0; c < CHANNELS; c++)
      if (stb.store[c]) table_q[stb.storeBank][c][storeIdx] <= stb.storeData;
  end

  always_comb begin
    rdEntry = '0;
    for (int c = 0; c < CHANNELS; c++)
      if (regAddr == 2'(c)) rdEntry = table_q[rdBank[c]][c][chIdx[c]];
    regRdata = (regAddr == MODE_ADDR) ? REG_W'(modeBits) : REG_W'(rdEntry);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOutValid <= 1'b0;
      pixOut      <= '0;
    end else begin
      pixOutValid <= pixInValid;
      if (pixInValid)
        for (int c = 0; c < CHANNELS; c++)
          pixOut[c*ENTRY_W +: ENTRY_W] <= lutOn
            ? table_q[pixBank][c][pixIn[c*IDX_W +: IDX_W]]
            : ENTRY_W'(pixIn[c*IDX_W +: IDX_W]);
    end
  end
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWr,
  input  logic                          regRd,
  input  logic [1:0]                    regAddr,
  input  logic [REG_W-1:0]              regWdata,
  output logic [REG_W-1:0]              regRdata,
  input  logic                          pixInValid,
  input  logic [CHANNELS*IDX_W-1:0]     pixIn,
  output logic                          pixOutValid,
  output logic [CHANNELS*ENTRY_W-1:0]   pixOut
);
  lut_strobe_t                     stb;
  logic [IDX_W-1:0]                storeIdx;
  logic [CHANNELS-1:0][IDX_W-1:0]  chIdx;
  logic [CHANNELS-1:0][BANK_W-1:0] rdBank;
  logic [MODE_W-1:0]               modeBits;
  logic                            lutOn;

  assign lutOn = modeBits[0];

  gamma_lut_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .stb(stb),
    .storeIdx(storeIdx), .chIdx(chIdx), .rdBank(rdBank),
    .modeBits(modeBits)
  );

  gamma_lut_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .storeIdx(storeIdx),
    .chIdx(chIdx), .rdBank(rdBank), .modeBits(modeBits),
    .regAddr(regAddr), .regRdata(regRdata),
    .pixInValid(pixInValid), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut)
  );
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWr,
  input logic                          regRd,
  input logic [1:0]                    regAddr,
  input logic [REG_W-1:0]              regRdata,
  input logic                          pixInValid,
  input logic [CHANNELS*IDX_W-1:0]     pixIn,
  input logic                          pixOutValid,
  input logic [CHANNELS*ENTRY_W-1:0]   pixOut,
  input logic                          lutOn
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!pixOutValid && pixOut == '0));

  p_one_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));

  p_port_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr != MODE_ADDR) |-> regRdata[REG_W-1:ENTRY_W] == '0);

  p_mode_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == MODE_ADDR) |-> regRdata[REG_W-1:MODE_W] == '0);

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    pixInValid |=> pixOutValid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pixInValid |=> (!pixOutValid && $stable(pixOut)));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_bypass
    p_bypass_zext_r10: assert property (@(posedge clk) disable iff (!rstN)
      (pixInValid && !lutOn) |=>
        pixOut[c*ENTRY_W +: ENTRY_W] == ENTRY_W'($past(pixIn[c*IDX_W +: IDX_W])));
  end
endmodule

bind gamma_lut gamma_lut_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
  .regAddr(regAddr), .regRdata(regRdata), .pixInValid(pixInValid),
  .pixIn(pixIn), .pixOutValid(pixOutValid), .pixOut(pixOut),
  .lutOn(lutOn)
);

// File: tb/sim_gamma_lut.sv
module sim_gamma_lut;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_B = 32'h0200_0000;
  localparam logic [31:0] ARM_B = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        pixInValid = 1'b0;
  logic [23:0] pixIn = 24'd0;
  logic        pixOutValid;
  logic [35:0] pixOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_lut u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pixInValid(pixInValid), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut)
  );

  function automatic logic [11:0] fv(int b, int c, int i);
    return 12'(b * 1031 + c * 409 + i * 37 + 5);
  endfunction

  function automatic logic [31:0] maskOf(int b);
    logic [3:0] m = 4'hF;
    m[b] = 1'b0;
    return {m, 28'd0};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic pix(logic [23:0] v);
    pixInValid = 1'b1; pixIn = v;
    @(negedge clk);
    pixInValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pixOutValid", 64'(pixOutValid), 64'd0);
    chk("R1 pixOut", 64'(pixOut), 64'd0);
    rd(2'd3, d);
    chk("R1 mode", 64'(d), 64'd0);

    // R3 R4 full interleaved load of every bank
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 256; i++)
        for (int c = 0; c < 3; c++)
          wr(2'(c), maskOf(b) | ((i == 0) ? RST_B : 32'd0) | 32'(fv(b, c, i)));

    // R6 R7 readback of all entries, then R3 wrap
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 3; c++) begin
        wr(2'(c), maskOf(b) | RST_B | ARM_B);
        for (int i = 0; i < 256; i++) begin
          rd(2'(c), d);
          chk("R7 readback", 64'(d), 64'(fv(b, c, i)));
        end
        rd(2'(c), d);
        chk("R3 index wrap", 64'(d), 64'(fv(b, c, 0)));
      end

    // R8 independent counters
    for (int c = 0; c < 3; c++) wr(2'(c), maskOf(0) | RST_B | ARM_B);
    for (int i = 0; i < 3; i++) rd(2'd0, d);
    rd(2'd1, d);
    chk("R8 ch1 own index", 64'(d), 64'(fv(0, 1, 0)));
    rd(2'd0, d);
    chk("R8 ch0 kept index", 64'(d), 64'(fv(0, 0, 3)));

    // R5 invalid masks: no store, no advance, reset flag still acts
    wr(2'd0, 32'hF000_0ABC);
    rd(2'd0, d);
    chk("R5 no-zero mask", 64'(d), 64'(fv(0, 0, 4)));
    wr(2'd0, 32'h3000_0ABC | RST_B);
    rd(2'd0, d);
    chk("R5 two-zero mask index reset", 64'(d), 64'(fv(0, 0, 0)));
    for (int b = 0; b < 4; b++) begin
      wr(2'd0, maskOf(b) | RST_B | ARM_B);
      rd(2'd0, d);
      chk("R5 entry untouched", 64'(d), 64'(fv(b, 0, 0)));
    end

    // R6 arm write stores nothing
    wr(2'd2, maskOf(1) | RST_B | ARM_B | 32'hFFF);
    rd(2'd2, d);
    chk("R6 arm no store", 64'(d), 64'(fv(1, 2, 0)));

    // R3 R4 partial overwrite then restore
    wr(2'd1, maskOf(2) | RST_B | 32'h123);
    wr(2'd1, maskOf(2) | 32'h456);
    wr(2'd1, maskOf(2) | RST_B | ARM_B);
    rd(2'd1, d); chk("R4 entry0", 64'(d), 64'h123);
    rd(2'd1, d); chk("R3 entry1", 64'(d), 64'h456);
    rd(2'd1, d); chk("R3 entry2 kept", 64'(d), 64'(fv(2, 1, 2)));
    wr(2'd1, maskOf(2) | RST_B | 32'(fv(2, 1, 0)));
    wr(2'd1, maskOf(2) | 32'(fv(2, 1, 1)));

    // R2 R9 lookup sweeps in every bank
    for (int b = 0; b < 4; b++) begin
      wr(2'd3, 32'(1 + 2 * b));
      rd(2'd3, d);
      chk("R2 mode readback", 64'(d), 64'(1 + 2 * b));
      for (int i = 0; i < 256; i++) begin
        logic [7:0] p0, p1, p2;
        p0 = 8'(i); p1 = 8'(255 - i); p2 = 8'(i) ^ 8'h5A;
        pix({p2, p1, p0});
        chk("R9 valid", 64'(pixOutValid), 64'd1);
        chk("R9 lookup", 64'(pixOut),
            64'({fv(b, 2, int'(p2)), fv(b, 1, int'(p1)), fv(b, 0, int'(p0))}));
      end
      @(negedge clk);
      chk("R9 valid drops", 64'(pixOutValid), 64'd0);
    end

    // R10 bypass sweep with a bank still selected
    wr(2'd3, 32'h6);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p0, p1, p2;
      p0 = 8'(i); p1 = 8'(i * 7); p2 = ~8'(i);
      pix({p2, p1, p0});
      chk("R10 bypass", 64'(pixOut), 64'({4'd0, p2, 4'd0, p1, 4'd0, p0}));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule